// File: doc/BRIEF.md
# Pipeline Raster Timing Source

This block drives the pixel stream that joins the stages of a streaming image pipeline. A free-running pixel clock advances a column counter and a line counter, one pixel position per clock. Each line has a run of active pixels followed by a horizontal blanking gap. Each frame has a run of active lines followed by vertical blanking lines. From these two counters the block produces an 8-bit grey-level bus, a per-pixel strobe, and the two blanking flags. The default frame is a 512 by 512 square with 16-clock line gaps.

The pixel value comes from one of two sources, chosen by a select input. One source is a built-in diagonal ramp, which a checker can predict from the raster position alone. The other is an external pixel port, passed through at the right position. The block also has a separate delay chain that carries a blanking pair and a strobe. A downstream processing stage uses it to re-emit those three signals shifted by exactly its own latency, so they stay aligned with its delayed data.

Top module: `vid_frame_gen`

## Requirements
- R1: While rst_n is low, hblank_o and vblank_o read 1, strobe_o and pix_o read 0, dly_hb_o and dly_vb_o read 1, and dly_stb_o reads 0.
- R2: The first clock edge after reset presents column 0 of line 0. Each line is ACT_PIX clocks with hblank_o at 0, followed by HBLANK clocks with hblank_o at 1. The horizontal pattern continues unchanged through the vertical blanking lines.
- R3: vblank_o is 0 for the first ACT_LINES lines of a frame and 1 for the following VBL_LINES lines. It changes only on the clock right after a clock with hblank_o at 1.
- R4: strobe_o is 1 exactly on the clocks where both hblank_o and vblank_o are 0.
- R5: When src_sel is 0 on the edge that presents an active position, pix_o equals (line + column) mod 2^PIX_W. Line and column count from 0.
- R6: When src_sel is 1 on the edge that presents an active position, pix_o equals the pix_in value sampled on that same edge.
- R7: pix_o is 0 on every blanking clock, whichever source is selected.
- R8: dly_hb_o, dly_vb_o and dly_stb_o equal dly_hb_i, dly_vb_i and dly_stb_i as they were sampled DLY edges earlier, counting the current edge as the first. Stages not yet filled since reset read 1, 1 and 0.
- R9: After the last blanking line the raster returns to line 0, column 0. The test pattern then restarts from value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Pixel source: 0 test ramp, 1 external port |
| pix_in | input | PIX_W | External pixel value |
| pix_o | output | PIX_W | Pixel data bus |
| strobe_o | output | 1 | Active-pixel qualifier |
| hblank_o | output | 1 | Horizontal blanking flag |
| vblank_o | output | 1 | Vertical blanking flag |
| dly_hb_i | input | 1 | Horizontal flag into the delay chain |
| dly_vb_i | input | 1 | Vertical flag into the delay chain |
| dly_stb_i | input | 1 | Strobe into the delay chain |
| dly_hb_o | output | 1 | Delayed horizontal flag |
| dly_vb_o | output | 1 | Delayed vertical flag |
| dly_stb_o | output | 1 | Delayed strobe |

## Verification
The generator runs with the ramp source over two full frames on a reduced raster, with a pixel width narrow enough that the ramp wraps inside one frame. This separates a correct modulo sum from a wrong width, and it shows a correct frame restart against a counter that fails to wrap. A second run feeds a changing sequence on the external port and toggles the source select within active lines. That separates the right sampling edge from an off-by-one latency, and it shows that blanking forces zero on both sources. Throughout, the delay chain gets an irregular bit pattern on each of its three inputs. A chain that is too short, too long, or has two inputs swapped fails against that pattern.

// File: rtl/vid_frame_gen.sv
module vid_frame_gen #(
  parameter int PIX_W     = 8,
  parameter int ACT_PIX   = 512,
  parameter int ACT_LINES = 512,
  parameter int HBLANK    = 16,
  parameter int VBL_LINES = 16,
  parameter int DLY       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_o,
  output logic             strobe_o,
  output logic             hblank_o,
  output logic             vblank_o,
  input  logic             dly_hb_i,
  input  logic             dly_vb_i,
  input  logic             dly_stb_i,
  output logic             dly_hb_o,
  output logic             dly_vb_o,
  output logic             dly_stb_o
);
  localparam int LINE_LEN    = ACT_PIX + HBLANK;
  localparam int FRAME_LINES = ACT_LINES + VBL_LINES;
  localparam int CW = $clog2(LINE_LEN);
  localparam int RW = $clog2(FRAME_LINES);
  localparam int MW = (CW > RW) ? CW : RW;
  localparam int SW = ((MW > PIX_W) ? MW : PIX_W) + 1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          col_act, row_act, eol, eof;
  logic [SW-1:0] ramp;

  assign col_act = col < CW'(ACT_PIX);
  assign row_act = row < RW'(ACT_LINES);
  assign eol     = col == CW'(LINE_LEN - 1);
  assign eof     = row == RW'(FRAME_LINES - 1);
  assign ramp    = SW'(col) + SW'(row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= eol ? '0 : col + 1'b1;
      if (eol) row <= eof ? '0 : row + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblank_o <= 1'b1;
      vblank_o <= 1'b1;
      strobe_o <= 1'b0;
      pix_o    <= '0;
    end else begin
      hblank_o <= !col_act;
      vblank_o <= !row_act;
      strobe_o <= col_act && row_act;
      if (col_act && row_act) pix_o <= src_sel ? pix_in : ramp[PIX_W-1:0];
      else                    pix_o <= '0;
    end
  end

  generate
    if (DLY == 0) begin : g_nodly
      assign dly_hb_o  = dly_hb_i;
      assign dly_vb_o  = dly_vb_i;
      assign dly_stb_o = dly_stb_i;
    end else begin : g_dly
      logic [DLY-1:0] hb_sr, vb_sr, stb_sr;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hb_sr  <= '1;
          vb_sr  <= '1;
          stb_sr <= '0;
        end else begin
          hb_sr[0]  <= dly_hb_i;
          vb_sr[0]  <= dly_vb_i;
          stb_sr[0] <= dly_stb_i;
          for (int i = 1; i < DLY; i++) begin
            hb_sr[i]  <= hb_sr[i-1];
            vb_sr[i]  <= vb_sr[i-1];
            stb_sr[i] <= stb_sr[i-1];
          end
        end
      end
      assign dly_hb_o  = hb_sr[DLY-1];
      assign dly_vb_o  = vb_sr[DLY-1];
      assign dly_stb_o = stb_sr[DLY-1];
    end
  endgenerate

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (!hblank_o && !vblank_o));

  // R7
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_o || vblank_o) |-> (pix_o == '0));

  // R3
  vflag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_o != $past(vblank_o)) |-> $past(hblank_o));

  // R2
  hgap_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hblank_o) |-> !strobe_o || !vblank_o);

  // R4
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> ($past(hblank_o) || $past(vblank_o)));
endmodule

// File: tb/tb_vid_frame_gen.sv
module tb_vid_frame_gen;
  localparam int PW = 4, AP = 12, AL = 6, HB = 4, VL = 2, DL = 3;
  localparam int LL = AP + HB, FL = AL + VL;

  logic clk = 0, rst_n = 0, src_sel = 0;
  logic [PW-1:0] pix_in = '0, pix_o;
  logic strobe_o, hblank_o, vblank_o;
  logic dly_hb_i = 0, dly_vb_i = 0, dly_stb_i = 0;
  logic dly_hb_o, dly_vb_o, dly_stb_o;

  int compared = 0, mismatched = 0;
  int pos = -1, edges = 0;
  logic [2:0] hist [0:63];
  int rem = 0;

  vid_frame_gen #(.PIX_W(PW), .ACT_PIX(AP), .ACT_LINES(AL), .HBLANK(HB),
                  .VBL_LINES(VL), .DLY(DL)) dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pix_in(pix_in),
    .pix_o(pix_o), .strobe_o(strobe_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
    .dly_hb_i(dly_hb_i), .dly_vb_i(dly_vb_i), .dly_stb_i(dly_stb_i),
    .dly_hb_o(dly_hb_o), .dly_vb_o(dly_vb_o), .dly_stb_o(dly_stb_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, pos);
    end
  endtask

  task automatic step(input logic sel, input logic [PW-1:0] din);
    logic [2:0] d;
    int c, r, src;
    logic act;
    src_sel = sel;
    pix_in = din;
    rem = (rem * 5 + 3) % 64;
    d = rem[2:0];
    {dly_hb_i, dly_vb_i, dly_stb_i} = d;
    @(posedge clk);
    pos++;
    edges++;
    hist[edges % 64] = d;
    @(negedge clk);
    c = pos % LL;
    r = (pos / LL) % FL;
    act = (c < AP) && (r < AL);
    chk("R2 hblank", int'(hblank_o), int'(c >= AP));
    chk("R3 vblank", int'(vblank_o), int'(r >= AL));
    chk("R4 strobe", int'(strobe_o), int'(act));
    if (!act) chk("R7 blank pix", int'(pix_o), 0);
    else if (sel) chk("R6 ext pix", int'(pix_o), int'(din));
    else chk("R5 ramp pix", int'(pix_o), (r + c) % (1 << PW));
    src = edges - DL + 1;
    if (src < 1) chk("R8 delay", int'({dly_hb_o, dly_vb_o, dly_stb_o}), 3'b110);
    else chk("R8 delay", int'({dly_hb_o, dly_vb_o, dly_stb_o}), int'(hist[src % 64]));
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 hblank", int'(hblank_o), 1);
    chk("R1 vblank", int'(vblank_o), 1);
    chk("R1 strobe", int'(strobe_o), 0);
    chk("R1 pix", int'(pix_o), 0);
    chk("R1 delay", int'({dly_hb_o, dly_vb_o, dly_stb_o}), 3'b110);
    pos = -1;
    edges = 0;
    rst_n = 1;
  endtask

  task automatic t_ramp_two_frames();
    for (int i = 0; i < 2 * LL * FL; i++) begin
      step(1'b0, PW'(i));
      if (pos == LL * FL) begin
        // R9 restart at line 0, column 0 with ramp value 0
        chk("R9 wrap vblank", int'(vblank_o), 0);
        chk("R9 wrap pix", int'(pix_o), 0);
      end
    end
  endtask

  task automatic t_external();
    for (int i = 0; i < LL * FL + 5; i++)
      step((i % 7) != 3, PW'(i * 7 + 1));
  endtask

  initial begin
    #20000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp_two_frames();
    t_reset();
    t_external();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule